// File: doc/BRIEF.md
# Quad Cascadable 8-bit Timer Unit

This block holds four independent 8-bit down-counters. Each counter has a reload register and is written over a small register bus. A write to a timer's offset stores the value as its reload and also places it in the live counter. Each timer then counts one step on every enable pulse from its chosen source. From a reload value n, a timer overflows once every n+1 pulses. At each overflow it reloads itself and raises a sticky interrupt request. Software clears that request by writing a zero to its bit.

Every timer picks its source from its own short menu. The menu offers taps of a free-running divider on the system clock, external pins (synchronised, counting falling edges), or the overflow of a partner timer. The partner path lets timer 1 act as a prescaler for timer 2, and timer 3 as a prescaler for timer 4. All counting runs in the single clock domain. Every source reaches a counter as a one-cycle enable, so no counter is clocked by a derived signal.

Top module: `quad_timer_unit`

## Requirements
- R1: Each counter decrements by exactly one on every enable pulse of its selected source and holds its value when there is no pulse, so a reload value n gives one overflow every n+1 pulses.
- R2: A bus write to offset 0, 1, 2 or 3 (timers 1 to 4) stores the data as that timer's reload value and loads it into the counter on the same edge; the load takes precedence over a coincident count pulse. Reading those offsets returns the live counter.
- R3: A count pulse that finds the counter at 0x00 is an overflow: the counter takes the reload value and the timer's request bit is set.
- R4: Timer 1 counts the clock divided by 16 when bit 0 of the pair-A mode register (offset 4) is 0, and the clock divided by 4096 when it is 1.
- R5: Timer 2 source, from the offset 4 register: bit 4 set selects the falling edges of pin_t2_clk (this wins over bit 1); otherwise bit 1 set selects timer 1 overflow; otherwise the clock divided by 16.
- R6: Timer 3 source, from the pair-B mode register (offset 5): bit 5 set selects the falling edges of pin_t3_clk (this wins over bit 0); otherwise bit 0 set selects the falling edges of pin_hsync; otherwise the clock divided by 16.
- R7: Timer 4 source, from the offset 5 register: bit 4 set selects timer 3 overflow (this wins over bit 1); otherwise bit 1 set selects the clock divided by 2; otherwise the clock divided by 16.
- R8: Each external pin passes through a two-flop synchroniser. A falling edge gives exactly one count pulse, which reaches the counter on the second clock edge after the edge is captured. Rising edges and steady levels give none.
- R9: The request bits sit at bits 0 to 3 of offset 6 (timers 1 to 4) and drive irq_req. A set bit stays set. Writing 0 to a bit clears it, and writing 1 leaves it unchanged. An overflow on the same edge as a clear leaves the bit set.
- R10: After reset every counter and reload register holds 0xFF, both mode registers hold 0x00, and every request bit is 0.
- R11: All counting runs on clk alone. The divided taps come from one free-running divider cleared at reset, and each tap is a one-cycle enable, so the divide-by-16 source gives one pulse every 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W (3) | Register offset: 0-3 timers, 4/5 mode registers, 6 request bits |
| bus_wdata | input | TMR_W (8) | Write data |
| bus_rdata | output | TMR_W (8) | Read data for bus_addr (combinational) |
| pin_t2_clk | input | 1 | External clock that timer 2 can select |
| pin_hsync | input | 1 | Horizontal-sync input that timer 3 can select |
| pin_t3_clk | input | 1 | External clock that timer 3 can select |
| irq_req | output | 4 | Sticky request bits, bit i for timer i+1 |

## Verification
The bench measures the spacing between successive overflows for each source on every timer. This catches an off-by-one divide: a counter that reloads without spending a pulse, or that counts a pulse at zero twice, gives n or n+2 instead of n+1. It sets both select bits together to show the priority of the higher bit; a reversed priority gives a period off by a clear factor. It drives a single external edge at a time to show that rising edges are ignored, and holds a clear write across two edges while a timer overflows every other cycle. A design where the clear beats the overflow loses that request.

// File: rtl/qtu_pkg.sv
package qtu_pkg;

  localparam int NUM_TIMERS = 4;
  localparam int NUM_EXT    = 3;

  // register offsets
  localparam int OFS_T1     = 0;
  localparam int OFS_T2     = 1;
  localparam int OFS_T3     = 2;
  localparam int OFS_T4     = 3;
  localparam int OFS_MODE_A = 4;
  localparam int OFS_MODE_B = 5;
  localparam int OFS_FLAGS  = 6;

  // select bit positions inside the two mode registers
  localparam int MA_T1_ALT = 0;
  localparam int MA_T2_ALT = 1;
  localparam int MA_T2_EXT = 4;
  localparam int MB_T3_ALT = 0;
  localparam int MB_T3_EXT = 5;
  localparam int MB_T4_ALT = 1;
  localparam int MB_T4_EXT = 4;

  typedef enum logic [1:0] {
    SRC_BASE = 2'd0,
    SRC_ALT  = 2'd1,
    SRC_EXT  = 2'd2
  } src_sel_e;

  // higher-numbered bit wins, lower-numbered bit next, else the base tap
  function automatic src_sel_e pick_source(input logic hi_bit, input logic lo_bit);
    if (hi_bit)      return SRC_EXT;
    else if (lo_bit) return SRC_ALT;
    else             return SRC_BASE;
  endfunction

  function automatic logic route_tick(input src_sel_e sel, input logic base,
                                      input logic alt, input logic ext);
    case (sel)
      SRC_ALT: return alt;
      SRC_EXT: return ext;
      default: return base;
    endcase
  endfunction

endpackage

// File: rtl/qtu_prescaler.sv
module qtu_prescaler #(
  parameter int SLOW_LOG2 = 12,
  parameter int MID_LOG2  = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_div2,
  output logic tick_mid,
  output logic tick_slow
);

  logic [SLOW_LOG2-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick_div2 = div_q[0];
  assign tick_mid  = &div_q[MID_LOG2-1:0];
  assign tick_slow = &div_q;

  // R11
  slow_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_slow |-> (tick_mid && tick_div2));

  // R11
  mid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_mid |=> !tick_mid);

endmodule

// File: rtl/qtu_edge_sync.sv
module qtu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_pulse
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_pulse = last_q & ~sync_q[STAGES-1];

  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/qtu_counter.sv
module qtu_counter #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic         ovf
);

  logic [W-1:0] latch_q;

  function automatic logic [W-1:0] step_down(input logic [W-1:0] cur,
                                             input logic [W-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  assign ovf = tick && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RST_VAL;
      latch_q <= RST_VAL;
    end else if (load) begin
      cnt_q   <= load_val;
      latch_q <= load_val;
    end else if (tick) begin
      cnt_q   <= step_down(cnt_q, latch_q);
    end
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)) && (latch_q == $past(load_val)));

  // R1
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt_q == $past(latch_q));

endmodule

// File: rtl/quad_timer_unit.sv
module quad_timer_unit
  import qtu_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int ADDR_W      = 3,
  parameter int SLOW_LOG2   = 12,
  parameter int MID_LOG2    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TMR_W-1:0]  bus_wdata,
  output logic [TMR_W-1:0]  bus_rdata,
  input  logic              pin_t2_clk,
  input  logic              pin_hsync,
  input  logic              pin_t3_clk,
  output logic [3:0]        irq_req
);

  localparam int PAD_W = TMR_W - NUM_TIMERS;

  // divided clock taps
  logic tick_div2, tick_div16, tick_div4096;

  qtu_prescaler #(.SLOW_LOG2(SLOW_LOG2), .MID_LOG2(MID_LOG2)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_div2 (tick_div2),
    .tick_mid  (tick_div16),
    .tick_slow (tick_div4096)
  );

  // external pins: index 0 timer-2 pin, 1 hsync, 2 timer-3 pin
  logic [NUM_EXT-1:0] pin_raw, pin_fall;
  assign pin_raw = {pin_t3_clk, pin_hsync, pin_t2_clk};

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_sync
    qtu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (pin_raw[g]),
      .fall_pulse (pin_fall[g])
    );
  end

  // bus decode
  logic load_t1, load_t2, load_t3, load_t4, mode_a_wr, mode_b_wr, flag_wr;
  assign load_t1   = bus_wr && (bus_addr == ADDR_W'(OFS_T1));
  assign load_t2   = bus_wr && (bus_addr == ADDR_W'(OFS_T2));
  assign load_t3   = bus_wr && (bus_addr == ADDR_W'(OFS_T3));
  assign load_t4   = bus_wr && (bus_addr == ADDR_W'(OFS_T4));
  assign mode_a_wr = bus_wr && (bus_addr == ADDR_W'(OFS_MODE_A));
  assign mode_b_wr = bus_wr && (bus_addr == ADDR_W'(OFS_MODE_B));
  assign flag_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_FLAGS));

  // mode registers
  logic [TMR_W-1:0] mode_a_q, mode_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_a_q <= '0;
      mode_b_q <= '0;
    end else begin
      if (mode_a_wr) mode_a_q <= bus_wdata;
      if (mode_b_wr) mode_b_q <= bus_wdata;
    end
  end

  // source selection, one named wire per timer
  src_sel_e sel_t1, sel_t2, sel_t3, sel_t4;
  assign sel_t1 = pick_source(1'b0,                mode_a_q[MA_T1_ALT]);
  assign sel_t2 = pick_source(mode_a_q[MA_T2_EXT], mode_a_q[MA_T2_ALT]);
  assign sel_t3 = pick_source(mode_b_q[MB_T3_EXT], mode_b_q[MB_T3_ALT]);
  assign sel_t4 = pick_source(mode_b_q[MB_T4_EXT], mode_b_q[MB_T4_ALT]);

  logic tick_t1, tick_t2, tick_t3, tick_t4;
  logic ovf_t1, ovf_t2, ovf_t3, ovf_t4;
  logic [TMR_W-1:0] cnt_t1, cnt_t2, cnt_t3, cnt_t4;

  assign tick_t1 = route_tick(sel_t1, tick_div16, tick_div4096, 1'b0);
  assign tick_t2 = route_tick(sel_t2, tick_div16, ovf_t1,       pin_fall[0]);
  assign tick_t3 = route_tick(sel_t3, tick_div16, pin_fall[1],  pin_fall[2]);
  assign tick_t4 = route_tick(sel_t4, tick_div16, tick_div2,    ovf_t3);

  qtu_counter #(.W(TMR_W)) u_t1 (
    .clk(clk), .rst_n(rst_n), .tick(tick_t1), .load(load_t1),
    .load_val(bus_wdata), .cnt_q(cnt_t1), .ovf(ovf_t1));

  qtu_counter #(.W(TMR_W)) u_t2 (
    .clk(clk), .rst_n(rst_n), .tick(tick_t2), .load(load_t2),
    .load_val(bus_wdata), .cnt_q(cnt_t2), .ovf(ovf_t2));

  qtu_counter #(.W(TMR_W)) u_t3 (
    .clk(clk), .rst_n(rst_n), .tick(tick_t3), .load(load_t3),
    .load_val(bus_wdata), .cnt_q(cnt_t3), .ovf(ovf_t3));

  qtu_counter #(.W(TMR_W)) u_t4 (
    .clk(clk), .rst_n(rst_n), .tick(tick_t4), .load(load_t4),
    .load_val(bus_wdata), .cnt_q(cnt_t4), .ovf(ovf_t4));

  // sticky request bits
  logic [NUM_TIMERS-1:0] ovf_v, irq_flags;
  assign ovf_v = {ovf_t4, ovf_t3, ovf_t2, ovf_t1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flags <= '0;
    end else begin
      for (int i = 0; i < NUM_TIMERS; i++) begin
        if (ovf_v[i])                       irq_flags[i] <= 1'b1;
        else if (flag_wr && !bus_wdata[i])  irq_flags[i] <= 1'b0;
      end
    end
  end

  assign irq_req = irq_flags;

  // read mux
  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_T1):     bus_rdata = cnt_t1;
      ADDR_W'(OFS_T2):     bus_rdata = cnt_t2;
      ADDR_W'(OFS_T3):     bus_rdata = cnt_t3;
      ADDR_W'(OFS_T4):     bus_rdata = cnt_t4;
      ADDR_W'(OFS_MODE_A): bus_rdata = mode_a_q;
      ADDR_W'(OFS_MODE_B): bus_rdata = mode_b_q;
      ADDR_W'(OFS_FLAGS):  bus_rdata = {{PAD_W{1'b0}}, irq_flags};
      default:             bus_rdata = '0;
    endcase
  end

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_v) |=> ((irq_flags & $past(ovf_v)) == $past(ovf_v)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|ovf_v) && !flag_wr) |=> $stable(irq_flags));

  // R7
  t4_cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b_q[MB_T4_EXT] && !ovf_t3 && !load_t4) |=> $stable(cnt_t4));

endmodule

// File: tb/quad_timer_unit_bench.sv
module quad_timer_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] irq;
  logic       gen_on = 1'b1;
  logic       man_t2 = 1'b1, man_hs = 1'b1, man_t3 = 1'b1;
  logic       pin_t2, pin_hs, pin_t3;
  int         gcnt = 0;
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) gcnt <= (gcnt == 119) ? 0 : gcnt + 1;

  // free-running pin patterns: periods 6, 10 and 8 clocks
  assign pin_t2 = gen_on ? ((gcnt % 6) < 3)  : man_t2;
  assign pin_hs = gen_on ? ((gcnt % 10) < 5) : man_hs;
  assign pin_t3 = gen_on ? ((gcnt % 8) < 4)  : man_t3;

  quad_timer_unit u_quad_timer_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_t2_clk(pin_t2), .pin_hsync(pin_hs), .pin_t3_clk(pin_t3),
    .irq_req(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    bus_addr = 3'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  // cycles between two successive overflows of timer t
  task automatic measure(input int t, output int period);
    int first;
    bit got;
    period = -1;
    first = 0;
    bus_write(6, 0);
    got = 1'b0;
    for (int w = 0; w < 20000 && !got; w++) begin
      @(negedge clk);
      if (irq[t]) begin got = 1'b1; first = cyc; end
    end
    if (!got) return;
    bus_write(6, 0);
    got = 1'b0;
    for (int w = 0; w < 20000 && !got; w++) begin
      @(negedge clk);
      if (irq[t]) begin got = 1'b1; period = cyc - first; end
    end
  endtask

  typedef struct packed {
    logic [7:0]  m_a;
    logic [7:0]  m_b;
    logic [31:0] lat;   // {t4, t3, t2, t1}
    logic [1:0]  idx;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'h00, 32'hFFFFFF03, 2'd0, 16'd64},    // R1 t1 /16, n=3
    '{8'h01, 8'h00, 32'hFFFFFF00, 2'd0, 16'd4096},  // R4 t1 /4096, n=0
    '{8'h00, 8'h00, 32'hFFFF05FF, 2'd1, 16'd96},    // R1 t2 /16, n=5
    '{8'h02, 8'h00, 32'hFFFF0301, 2'd1, 16'd128},   // R5 t2 on t1 ovf: 2*4*16
    '{8'h12, 8'h00, 32'hFFFF04FF, 2'd1, 16'd30},    // R5 pin wins: 5*6
    '{8'h00, 8'h00, 32'hFF02FFFF, 2'd2, 16'd48},    // R6 t3 /16, n=2
    '{8'h00, 8'h01, 32'hFF03FFFF, 2'd2, 16'd40},    // R6 hsync: 4*10
    '{8'h00, 8'h21, 32'hFF01FFFF, 2'd2, 16'd16},    // R6 pin wins: 2*8
    '{8'h00, 8'h02, 32'h09FFFFFF, 2'd3, 16'd20},    // R7 t4 /2: 10*2
    '{8'h00, 8'h12, 32'h0102FFFF, 2'd3, 16'd96},    // R7 cascade wins: 3*16*2
    '{8'h00, 8'h00, 32'h00FFFFFF, 2'd3, 16'd16}     // R11 /16 tap, n=0
  };

  function automatic string req_of(input int k);
    case (k)
      0, 2:    return "R1 period";
      1:       return "R4 period";
      3, 4:    return "R5 period";
      5, 6, 7: return "R6 period";
      8, 9:    return "R7 period";
      default: return "R11 period";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=190000 cycles expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, per, s1, s2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int t = 0; t < 4; t++) begin
      bus_read(t, v);
      chk("R10 counter reset", v, 255);
    end
    bus_read(4, v); chk("R10 mode A reset", v, 0);
    bus_read(5, v); chk("R10 mode B reset", v, 0);
    bus_read(6, v); chk("R10 flags reset", v, 0);
    chk("R10 irq port reset", int'(irq), 0);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      bus_write(4, int'(VECS[k].m_a));
      bus_write(5, int'(VECS[k].m_b));
      for (int t = 0; t < 4; t++) bus_write(t, int'(VECS[k].lat[t*8 +: 8]));
      measure(int'(VECS[k].idx), per);
      chk(req_of(k), per, int'(VECS[k].exp));
    end

    // R2 load, R1 decrement, R3 overflow: timer 4 on the /2 tap
    bus_write(5, 8'h02);
    bus_write(3, 10);
    bus_read(3, v); chk("R2 load to counter", v, 10);
    bus_write(6, 0);                       // two more edges: one tick
    bus_read(3, v); chk("R1 one decrement", v, 9);
    repeat (18) @(negedge clk);
    bus_read(3, v); chk("R1 reaches zero", v, 0);
    chk("R3 no request before overflow", int'(irq[3]), 0);
    repeat (2) @(negedge clk);
    bus_read(3, v); chk("R3 reload after overflow", v, 10);
    chk("R3 request on overflow", int'(irq[3]), 1);

    // R9 overflow beats a coincident clear (timer 4 overflows every 2 clocks)
    bus_write(3, 0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h00;
    @(negedge clk); s1 = int'(irq[3]);
    @(negedge clk); s2 = int'(irq[3]);
    bus_wr = 1'b0;
    chk("R9 set wins over clear", s1 + s2, 1);

    // R9 write 1 keeps, write 0 clears (timer 1)
    bus_write(4, 8'h00);
    bus_write(0, 0);
    v = 0;
    for (int w = 0; w < 40 && v == 0; w++) begin
      @(negedge clk);
      v = int'(irq[0]);
    end
    bus_write(0, 8'hFF);
    bus_write(6, 8'h01);
    chk("R9 write one keeps bit", int'(irq[0]), 1);
    bus_write(6, 8'h0E);
    chk("R9 write zero clears bit", int'(irq[0]), 0);
    bus_read(6, v); chk("R9 flag register bit 0", v & 1, 0);

    // R8 falling edges only, timer 3 on its pin
    gen_on = 1'b0;
    repeat (6) @(negedge clk);
    bus_write(5, 8'h20);
    bus_write(2, 5);
    repeat (4) @(negedge clk);
    bus_read(2, v); chk("R8 steady high no count", v, 5);
    man_t3 = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(2, v); chk("R8 falling edge counts once", v, 4);
    man_t3 = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(2, v); chk("R8 rising edge ignored", v, 4);
    man_t3 = 1'b0;
    @(negedge clk);
    bus_read(2, v); chk("R8 not yet through synchroniser", v, 4);
    @(negedge clk);
    @(negedge clk);
    bus_read(2, v); chk("R8 second edge counted", v, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule